// File: doc/BRIEF.md
# Unsigned Divide Unit with Condition Flags

This block performs unsigned integer division for a 32-bit integer core. A request carries a 32-bit dividend, a divisor, a width select (full word or halfword divisor), two destination register indices (one for the quotient, one for the remainder) and the current condition flags. The unit accepts the request with a single-cycle `start_i` pulse. It then works out one quotient bit per clock using restoring shift-subtract. It returns the quotient, the remainder, the latched indices, per-destination write enables and the updated flags in a one-cycle `done_o` window.

A zero divisor is detected when the request is accepted. That path finishes in a single cycle: it sets the overflow flag, suppresses both register writes, and leaves every other flag as it was. On a successful divide, the zero and sign flags are derived from the quotient; the remainder plays no part in them. When both destination indices name the same register, the quotient write enable is held low so that only the remainder lands there.

The controller has three states:
- **IDLE**: waiting for a request.
- **RUN**: iterating.
- **DONE**: results valid.

It has four transitions:
- **IDLE→RUN**: accept with a non-zero divisor.
- **IDLE→DONE**: accept with a zero divisor.
- **RUN→DONE**: after the last quotient bit.
- **DONE→IDLE**: always, after one cycle.

Top module: `udiv_flags_unit`

## Requirements
- R1: In word mode, `quot_o` equals dividend ÷ divisor and `rem_o` equals dividend mod divisor, for the full 32-bit operands.
- R2: When `half_i` is 1, only `divisor_i[15:0]` is used as the divisor; the dividend stays 32 bits wide.
- R3: When the effective divisor is zero, `quot_we_o` and `rem_we_o` stay 0, OV (`flags_o[2]`) is 1, and Z (`flags_o[0]`) and S (`flags_o[1]`) equal the values given on `flags_i` at accept.
- R4: CY (`flags_o[3]`) and SAT (`flags_o[4]`) always equal the values given on `flags_i` at accept.
- R5: On a successful divide, OV is 0, Z is 1 exactly when the quotient is zero, and S equals bit 31 of the quotient.
- R6: On a successful divide, `rem_we_o` is 1. `quot_we_o` is 1 only if `qdst_i` differs from `rdst_i`, so that a shared destination receives the remainder.
- R7: `done_o` is a one-cycle pulse and the write enables are high only with it. Counting the edge that accepts `start_i` as edge 1, `done_o` is visible after edge 33 for a non-zero divisor and after edge 1 for a zero divisor. `busy_o` is high from the accepting edge until `done_o` falls.
- R8: `start_i` and the operand inputs are ignored while `busy_o` is 1.
- R9: After reset, `busy_o`, `done_o`, `quot_we_o` and `rem_we_o` are 0.
- R10: `qdst_o` and `rdst_o` return the indices latched when the request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only when idle |
| half_i | input | 1 | 1 = use only the low 16 bits of the divisor |
| dividend_i | input | 32 | Dividend |
| divisor_i | input | 32 | Divisor |
| qdst_i | input | 5 | Quotient destination index |
| rdst_i | input | 5 | Remainder destination index |
| flags_i | input | 5 | Current flags {SAT,CY,OV,S,Z} |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Results valid this cycle |
| quot_o | output | 32 | Quotient |
| rem_o | output | 32 | Remainder |
| qdst_o | output | 5 | Latched quotient destination |
| rdst_o | output | 5 | Latched remainder destination |
| quot_we_o | output | 1 | Quotient write enable |
| rem_we_o | output | 1 | Remainder write enable |
| flags_o | output | 5 | Updated flags {SAT,CY,OV,S,Z} |

## Verification
All results (quotient, remainder, indices, write enables and flags) are due in the single cycle where `done_o` is high. That cycle follows edge 33 after acceptance for a non-zero divisor, and edge 1 for a zero divisor. The bench drives a request on a falling edge and counts rising edges from the accepting one, sampling on each falling edge. It checks that `done_o` first appears exactly at the expected count, then samples every result in that same half-cycle. The check of ignored `start_i` uses a pulse held during RUN. It then compares both the result and the latency against the first request.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } udiv_state_e;

    localparam int FLAG_W   = 5;
    localparam int FLG_Z    = 0;
    localparam int FLG_S    = 1;
    localparam int FLG_OV   = 2;
    localparam int FLG_CY   = 3;
    localparam int FLG_SAT  = 4;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
    import udiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic div_zero_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o,
    output logic done_o,
    output logic dz_o
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam int LAT_W = $clog2(W + 1) + 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(W - 1);

    udiv_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             dz_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = div_zero_i ? ST_DONE : ST_RUN;
            ST_RUN:  if (cnt_q == LAST_STEP) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration counter and zero-divisor capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dz_q  <= 1'b0;
        end else if (accept) begin
            cnt_q <= '0;
            dz_q  <= div_zero_i;
        end else if (state_q == ST_RUN) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_o = accept;
        step_o = (state_q == ST_RUN);
        busy_o = (state_q != ST_IDLE);
        done_o = (state_q == ST_DONE);
        dz_o   = dz_q;
    end

    // latency watcher, cycles since accept
    logic [LAT_W-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     lat_q <= '0;
        else if (accept)                lat_q <= '0;
        else if (state_q == ST_RUN)     lat_q <= lat_q + 1'b1;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_RUN_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !dz_q) |-> (lat_q == LAT_W'(W))); // R7
    AST_ZERO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_q) |-> (lat_q == '0)); // R7
    AST_RUN_NOT_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q != ST_IDLE)); // R8
endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] quo_q, rem_q, dvs_q;
    logic [W:0]   shifted, trial;
    logic         borrow;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_q};
        borrow  = trial[W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
        end else if (load_i) begin
            quo_q <= dividend_i;
            rem_q <= '0;
            dvs_q <= divisor_i;
        end else if (step_i) begin
            rem_q <= borrow ? shifted[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], ~borrow};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    AST_PARTIAL_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dvs_q != '0) |=> (rem_q < dvs_q)); // R1
endmodule

// File: rtl/udiv_flags.sv
module udiv_flags
    import udiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              dz_i,
    input  logic [W-1:0]      quo_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= '0;
        else if (load_i) held_q <= flags_i;
    end

    always_comb begin
        flags_o = held_q;
        if (dz_i) begin
            flags_o[FLG_OV] = 1'b1;
        end else begin
            flags_o[FLG_OV] = 1'b0;
            flags_o[FLG_Z]  = (quo_i == '0);
            flags_o[FLG_S]  = quo_i[W-1];
        end
    end
endmodule

// File: rtl/udiv_flags_unit.sv
module udiv_flags_unit
    import udiv_pkg::*;
#(
    parameter int W      = 32,
    parameter int HALF_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              half_i,
    input  logic [W-1:0]      dividend_i,
    input  logic [W-1:0]      divisor_i,
    input  logic [IDX_W-1:0]  qdst_i,
    input  logic [IDX_W-1:0]  rdst_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [W-1:0]      quot_o,
    output logic [W-1:0]      rem_o,
    output logic [IDX_W-1:0]  qdst_o,
    output logic [IDX_W-1:0]  rdst_o,
    output logic              quot_we_o,
    output logic              rem_we_o,
    output logic [FLAG_W-1:0] flags_o
);
    logic [W-1:0] divisor_eff;
    logic         div_zero, load, step, dz;
    logic [IDX_W-1:0] qdst_q, rdst_q;

    // operand width select
    always_comb begin
        divisor_eff = divisor_i;
        if (half_i) divisor_eff = {{(W-HALF_W){1'b0}}, divisor_i[HALF_W-1:0]};
        div_zero = (divisor_eff == '0);
    end

    udiv_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_zero_i(div_zero),
        .load_o(load), .step_o(step), .busy_o(busy_o), .done_o(done_o), .dz_o(dz)
    );

    udiv_datapath #(.W(W)) u_dp (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .dividend_i(dividend_i), .divisor_i(divisor_eff),
        .quo_o(quot_o), .rem_o(rem_o)
    );

    udiv_flags #(.W(W)) u_flg (
        .clk(clk), .rst_n(rst_n), .load_i(load), .flags_i(flags_i),
        .dz_i(dz), .quo_i(quot_o), .flags_o(flags_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qdst_q <= '0;
            rdst_q <= '0;
        end else if (load) begin
            qdst_q <= qdst_i;
            rdst_q <= rdst_i;
        end
    end

    always_comb begin
        qdst_o    = qdst_q;
        rdst_o    = rdst_q;
        rem_we_o  = done_o && !dz;
        quot_we_o = done_o && !dz && (qdst_q != rdst_q);
    end

    AST_DZ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && flags_o[FLG_OV]) |-> (!quot_we_o && !rem_we_o)); // R3
    AST_OV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        rem_we_o |-> !flags_o[FLG_OV]); // R5
    AST_Z_FROM_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
        rem_we_o |-> (flags_o[FLG_Z] == (quot_o == '0))); // R5
    AST_SHARED_DST: assert property (@(posedge clk) disable iff (!rst_n)
        quot_we_o |-> (rem_we_o && qdst_o != rdst_o)); // R6
    AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (quot_we_o || rem_we_o) |-> done_o); // R7
    AST_DONE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R7
endmodule

// File: tb/udiv_flags_unit_test.sv
module udiv_flags_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, half_i = 1'b0;
    logic [31:0] dividend_i = '0, divisor_i = '0;
    logic [4:0]  qdst_i = '0, rdst_i = '0, flags_i = '0;
    logic        busy_o, done_o, quot_we_o, rem_we_o;
    logic [31:0] quot_o, rem_o;
    logic [4:0]  qdst_o, rdst_o, flags_o;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk; // 50 MHz

    udiv_flags_unit uut (.*);

    // captured results
    logic [31:0] g_q, g_r;
    logic [4:0]  g_f, g_qd, g_rd;
    logic        g_qwe, g_rwe;
    int          g_lat;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wait_done();
        g_lat = 1;
        while (!done_o && g_lat < 200) begin
            @(negedge clk);
            g_lat++;
        end
        g_q = quot_o; g_r = rem_o; g_f = flags_o;
        g_qd = qdst_o; g_rd = rdst_o; g_qwe = quot_we_o; g_rwe = rem_we_o;
    endtask

    task automatic run(input logic [31:0] dvd, input logic [31:0] dvs, input logic hf,
                       input logic [4:0] qd, input logic [4:0] rd, input logic [4:0] fl);
        @(negedge clk);
        dividend_i = dvd; divisor_i = dvs; half_i = hf;
        qdst_i = qd; rdst_i = rd; flags_i = fl; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        dividend_i = 32'hDEAD_BEEF; divisor_i = 32'h1; flags_i = ~fl;
        wait_done();
    endtask

    task automatic t_reset();
        chk("R9", "busy", {31'd0, busy_o}, 0);
        chk("R9", "done", {31'd0, done_o}, 0);
        chk("R9", "we", {30'd0, quot_we_o, rem_we_o}, 0);
    endtask

    task automatic t_word(input logic [31:0] a, input logic [31:0] b);
        run(a, b, 1'b0, 5'd3, 5'd4, 5'b00000);
        chk("R1", "quot", g_q, a / b);
        chk("R1", "rem", g_r, a % b);
        chk("R7", "latency", g_lat, 33);
        chk("R5", "flags", {27'd0, g_f},
            {27'd0, 2'b00, 1'b0, (a / b) >> 31 != 0 ? 1'b1 : 1'b0, (a / b) == 0 ? 1'b1 : 1'b0});
        chk("R6", "we", {30'd0, g_qwe, g_rwe}, 32'd3);
        chk("R10", "idx", {22'd0, g_qd, g_rd}, {22'd0, 5'd3, 5'd4});
        @(negedge clk);
        chk("R7", "done pulse", {30'd0, done_o, busy_o}, 0);
    endtask

    task automatic t_half();
        run(32'd45, 32'h0001_0006, 1'b1, 5'd1, 5'd2, 5'b00000);
        chk("R2", "quot", g_q, 32'd7);
        chk("R2", "rem", g_r, 32'd3);
        run(32'h0009_0000, 32'hFFFF_0010, 1'b1, 5'd1, 5'd2, 5'b00000);
        chk("R2", "quot full dividend", g_q, 32'h0000_9000);
        run(32'd45, 32'h0001_0000, 1'b1, 5'd1, 5'd2, 5'b00000);
        chk("R2", "low half zero is div0", {31'd0, g_rwe}, 0);
        chk("R2", "ov", {31'd0, g_f[2]}, 1);
    endtask

    task automatic t_div0(input logic [4:0] fl);
        run(32'd45, 32'd0, 1'b0, 5'd2, 5'd3, fl);
        chk("R3", "we", {30'd0, g_qwe, g_rwe}, 0);
        chk("R3", "flags Z S OV", {29'd0, g_f[2:0]}, {29'd0, 1'b1, fl[1:0]});
        chk("R4", "flags CY SAT", {30'd0, g_f[4:3]}, {30'd0, fl[4:3]});
        chk("R7", "div0 latency", g_lat, 1);
    endtask

    task automatic t_flags();
        run(32'd0, 32'd45, 1'b0, 5'd1, 5'd2, 5'b11111);
        chk("R5", "zero dividend q r", {g_q[15:0], g_r[15:0]}, 0);
        chk("R5", "zero dividend flags", {27'd0, g_f}, {27'd0, 5'b11001});
        run(32'd16, 32'd45, 1'b0, 5'd1, 5'd2, 5'b00110);
        chk("R5", "Z from quotient", {27'd0, g_f}, {27'd0, 5'b00001});
        chk("R1", "rem 16", g_r, 32'd16);
        run(32'h8000_0000, 32'd1, 1'b0, 5'd1, 5'd2, 5'b01000);
        chk("R5", "S from quot bit31", {27'd0, g_f}, {27'd0, 5'b01010});
        chk("R4", "CY kept", {31'd0, g_f[3]}, 1);
    endtask

    task automatic t_shared();
        run(32'd45, 32'd6, 1'b0, 5'd7, 5'd7, 5'b00000);
        chk("R6", "shared dst quot_we", {31'd0, g_qwe}, 0);
        chk("R6", "shared dst rem_we", {31'd0, g_rwe}, 1);
        chk("R6", "rem value", g_r, 32'd3);
    endtask

    task automatic t_ignore();
        @(negedge clk);
        dividend_i = 32'd100; divisor_i = 32'd7; half_i = 0;
        qdst_i = 5'd9; rdst_i = 5'd10; flags_i = 0; start_i = 1;
        @(negedge clk);
        start_i = 0;
        chk("R7", "busy after accept", {31'd0, busy_o}, 1);
        for (int i = 0; i < 5; i++) @(negedge clk);
        dividend_i = 32'd9; divisor_i = 32'd0; qdst_i = 5'd1; rdst_i = 5'd1; start_i = 1;
        @(negedge clk);
        @(negedge clk);
        start_i = 0;
        g_lat = 8;
        while (!done_o && g_lat < 200) begin @(negedge clk); g_lat++; end
        chk("R8", "quot", quot_o, 32'd14);
        chk("R8", "rem", rem_o, 32'd2);
        chk("R8", "idx", {22'd0, qdst_o, rdst_o}, {22'd0, 5'd9, 5'd10});
        chk("R8", "latency", g_lat, 33);
        @(negedge clk);
        chk("R8", "idle after", {31'd0, busy_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word(32'd45, 32'd6);
        t_word(32'h4000_0000, 32'd4);
        t_word(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_word(32'hFFFF_FFFF, 32'h10);
        t_word(32'd5, 32'd9);
        t_word(32'h8765_4321, 32'd3);
        t_half();
        t_div0(5'b00000);
        t_div0(5'b11111);
        t_div0(5'b01010);
        t_flags();
        t_shared();
        t_ignore();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule